// File: doc/BRIEF.md
# Single-channel memory copy and fill engine

This block is one DMA channel behind a 128-byte register window. Software loads a source address, a destination address, a byte length, a command word and a 32-bit fill pattern. It then writes the control register to launch the job. The engine has two jobs. It can move words from the source range to the destination range (copy), or it can stamp the fill pattern over the destination range (fill). It does this over a word-wide memory master port with a request/grant handshake.

While a job runs, software can poll a busy flag or cancel the job. When the job ends, a sticky status register reports the outcome. A failing job leaves its source, destination and length in three capture registers. A level interrupt is driven from a write-1-to-clear interrupt status register. Completion is signalled only for jobs that ask for it. Any error is always signalled.

Top module: `dmx_channel`

## Requirements
- R1: After reset, every readable register reads 0, `mem_req` is low and `irq` is low.
- R2: A copy job (command bits [7:0] = 0x00) reads the word at source+4k and then writes that value to destination+4k, for k = 0 up to length/4-1 in rising order. A request keeps its address, write flag and data stable until it is granted.
- R3: A fill job (command bits [7:0] = 0x0C) writes the fill register value (offset 0x34) to destination+4k for every k below length/4. It issues no reads.
- R4: Status bit 0 (offset 0x24) reads 1 from the cycle after an accepted start until the final write is granted, and 0 otherwise. A control write (offset 0x1C) with bit 0 = 1 starts a job only while the channel is idle.
- R5: When a job completes, interrupt status bit 0 (offset 0x28) is set only if command bit 12 was 1 at the start.
- R6: A start with length 0 makes no memory access. It sets status bit 20 and bit 1, and sets interrupt status bit 1.
- R7: A start with a command code other than 0x00 or 0x0C, or with length bits [1:0] not equal to 0, makes no memory access. It sets status bit 18 and bit 1, and sets interrupt status bit 1. The zero-length check takes precedence over this one.
- R8: A grant that comes with `mem_err` ends the job. On a read it sets status bit 16, and on a write it sets status bit 17. In both cases it also sets status bit 1 and interrupt status bit 1.
- R9: On any error, the error source, destination and length registers (offsets 0x40, 0x44, 0x48) capture the failing job's source, destination and length.
- R10: A control write with bit 0 = 0 while the channel is busy stops the job. No further request is made, status bit 1 is set and no interrupt status bit is set.
- R11: Writing a 1 to an interrupt status bit clears it. `irq` is high exactly while any interrupt status bit is 1.
- R12: An accepted start clears status bits 1, 16, 17, 18 and 20 left over from an earlier job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset in the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Grant; completes the request in this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| mem_err | input | 1 | Error response, valid with the grant |
| irq | output | 1 | Level interrupt |

## Verification
The bench attacks the launch-time checks: zero length, an unknown command code and an unaligned length. A design that screened these wrongly would touch memory, or would report the wrong status bit, for example the illegal-configuration bit for a zero length. The bench injects an error response on the third read of a copy and on the second write of a fill. A design that kept going after the error, or that put the cause in the wrong bit, would leave extra destination words written or report the wrong status word. A cancel issued mid-copy must stop all requests and raise no interrupt, and the bench counts grants after the cancel to prove it. Quiet completions, write-1-to-clear, and the clearing of stale error bits by a fresh start are each checked at the register port.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int REG_W      = 32;
  localparam int REG_AW     = 7;
  localparam int WORD_BYTES = REG_W / 8;
  localparam int OP_W       = 8;
  localparam int CMD_IRQ    = 12;

  localparam logic [OP_W-1:0] OP_COPY = 8'h00;
  localparam logic [OP_W-1:0] OP_FILL = 8'h0C;

  localparam logic [REG_AW-1:0] OFF_SRC  = 7'h00;
  localparam logic [REG_AW-1:0] OFF_DST  = 7'h04;
  localparam logic [REG_AW-1:0] OFF_LEN  = 7'h08;
  localparam logic [REG_AW-1:0] OFF_CMD  = 7'h0C;
  localparam logic [REG_AW-1:0] OFF_CTL  = 7'h1C;
  localparam logic [REG_AW-1:0] OFF_STAT = 7'h24;
  localparam logic [REG_AW-1:0] OFF_INT  = 7'h28;
  localparam logic [REG_AW-1:0] OFF_FILL = 7'h34;
  localparam logic [REG_AW-1:0] OFF_ESRC = 7'h40;
  localparam logic [REG_AW-1:0] OFF_EDST = 7'h44;
  localparam logic [REG_AW-1:0] OFF_ELEN = 7'h48;

  localparam int ST_BUSY_B  = 0;
  localparam int ST_ABORT_B = 1;
  localparam int ST_RDERR_B = 16;
  localparam int ST_WRERR_B = 17;
  localparam int ST_ILL_B   = 18;
  localparam int ST_ZERO_B  = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_state_t;
  typedef enum logic [2:0] {C_NONE, C_RD, C_WR, C_ILL, C_ZERO} err_cause_t;

  function automatic logic op_legal(input logic [REG_W-1:0] cmd);
    return (cmd[OP_W-1:0] == OP_COPY) || (cmd[OP_W-1:0] == OP_FILL);
  endfunction

  function automatic logic op_is_fill(input logic [REG_W-1:0] cmd);
    return cmd[OP_W-1:0] == OP_FILL;
  endfunction

  function automatic logic len_aligned(input logic [REG_W-1:0] len);
    return (len % WORD_BYTES) == 0;
  endfunction

  function automatic logic [REG_W-1:0] addr_step(input logic [REG_W-1:0] a);
    return a + REG_W'(WORD_BYTES);
  endfunction

  function automatic logic [REG_W-1:0] cause_bits(input err_cause_t c);
    logic [REG_W-1:0] m;
    m = '0;
    if (c != C_NONE) m[ST_ABORT_B] = 1'b1;
    case (c)
      C_RD:    m[ST_RDERR_B] = 1'b1;
      C_WR:    m[ST_WRERR_B] = 1'b1;
      C_ILL:   m[ST_ILL_B]   = 1'b1;
      C_ZERO:  m[ST_ZERO_B]  = 1'b1;
      default: ;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dmx_engine.sv
module dmx_engine
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cancel,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [REG_W-1:0]  cfg_cmd,
  input  logic [REG_W-1:0]  cfg_fill,
  input  logic              mem_gnt,
  input  logic [REG_W-1:0]  mem_rdata,
  input  logic              mem_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]  mem_wdata,
  output logic              busy,
  output logic              ev_done_irq,
  output logic              ev_err,
  output err_cause_t        ev_cause,
  output logic              ev_cancel,
  output logic [ADDR_W-1:0] cap_src,
  output logic [ADDR_W-1:0] cap_dst,
  output logic [LEN_W-1:0]  cap_len
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(WORD_BYTES);

  eng_state_t        state_q;
  logic [ADDR_W-1:0] src_cur, dst_cur, job_src, job_dst;
  logic [LEN_W-1:0]  left_q, job_len;
  logic [REG_W-1:0]  data_q, job_fill;
  logic              job_fill_mode, job_irq;

  logic start_acc, cfg_zero, cfg_ill, cfg_bad, beat, last_beat;

  assign busy      = (state_q != ST_IDLE);
  assign start_acc = start && !busy;
  assign cfg_zero  = (cfg_len == '0);
  assign cfg_ill   = !op_legal(cfg_cmd) || !len_aligned(REG_W'(cfg_len));
  assign cfg_bad   = cfg_zero || cfg_ill;
  assign ev_cancel = cancel && busy;
  assign beat      = mem_req && mem_gnt && !ev_cancel;
  assign last_beat = (state_q == ST_WR) && beat && !mem_err && (left_q == STEP);

  assign mem_req   = busy;
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? dst_cur : src_cur;
  assign mem_wdata = job_fill_mode ? job_fill : data_q;

  assign ev_done_irq = last_beat && job_irq;
  assign cap_src = busy ? job_src : cfg_src;
  assign cap_dst = busy ? job_dst : cfg_dst;
  assign cap_len = busy ? job_len : cfg_len;

  always_comb begin
    ev_err   = 1'b0;
    ev_cause = C_NONE;
    if (start_acc && cfg_zero) begin
      ev_err = 1'b1; ev_cause = C_ZERO;
    end else if (start_acc && cfg_ill) begin
      ev_err = 1'b1; ev_cause = C_ILL;
    end else if (beat && mem_err) begin
      ev_err = 1'b1; ev_cause = (state_q == ST_RD) ? C_RD : C_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_cur <= '0; dst_cur <= '0; left_q <= '0;
      job_src <= '0; job_dst <= '0; job_len <= '0;
      job_fill <= '0; data_q <= '0;
      job_fill_mode <= 1'b0; job_irq <= 1'b0;
    end else if (!busy) begin
      if (start_acc && !cfg_bad) begin
        src_cur <= cfg_src; dst_cur <= cfg_dst; left_q <= cfg_len;
        job_src <= cfg_src; job_dst <= cfg_dst; job_len <= cfg_len;
        job_fill <= cfg_fill;
        job_fill_mode <= op_is_fill(cfg_cmd);
        job_irq <= cfg_cmd[CMD_IRQ];
        state_q <= op_is_fill(cfg_cmd) ? ST_WR : ST_RD;
      end
    end else if (ev_cancel) begin
      state_q <= ST_IDLE;
    end else if (beat) begin
      if (mem_err) begin
        state_q <= ST_IDLE;
      end else if (state_q == ST_RD) begin
        data_q  <= mem_rdata;
        src_cur <= ADDR_W'(addr_step(REG_W'(src_cur)));
        state_q <= ST_WR;
      end else begin
        dst_cur <= ADDR_W'(addr_step(REG_W'(dst_cur)));
        left_q  <= left_q - STEP;
        if (last_beat)          state_q <= ST_IDLE;
        else if (job_fill_mode) state_q <= ST_WR;
        else                    state_q <= ST_RD;
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cancel) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3
  fill_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && job_fill_mode) |-> mem_we);

  // R7
  bad_cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && cfg_bad) |=> !mem_req);

  // R6
  zero_len_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_acc && cfg_zero) |-> (ev_err && ev_cause == C_ZERO));
endmodule

// File: rtl/dmx_regs.sv
module dmx_regs
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [ADDR_W-1:0] cfg_src,
  output logic [ADDR_W-1:0] cfg_dst,
  output logic [LEN_W-1:0]  cfg_len,
  output logic [REG_W-1:0]  cfg_cmd,
  output logic [REG_W-1:0]  cfg_fill,
  output logic              start,
  output logic              cancel,
  input  logic              busy,
  input  logic              ev_done_irq,
  input  logic              ev_err,
  input  err_cause_t        ev_cause,
  input  logic              ev_cancel,
  input  logic [ADDR_W-1:0] cap_src,
  input  logic [ADDR_W-1:0] cap_dst,
  input  logic [LEN_W-1:0]  cap_len,
  output logic              irq
);
  logic [REG_W-1:0]  stat_q, stat_n;
  logic [1:0]        intr_q, intr_n;
  logic [ADDR_W-1:0] esrc_q, edst_q;
  logic [LEN_W-1:0]  elen_q;
  logic              ctl_wr, int_wr;

  assign ctl_wr = reg_we && (reg_addr == OFF_CTL);
  assign int_wr = reg_we && (reg_addr == OFF_INT);
  assign start  = ctl_wr && reg_wdata[0];
  assign cancel = ctl_wr && !reg_wdata[0];
  assign irq    = |intr_q;

  always_comb begin
    stat_n = stat_q;
    if (start && !busy) stat_n = '0;
    if (ev_err)         stat_n = stat_n | cause_bits(ev_cause);
    if (ev_cancel)      stat_n[ST_ABORT_B] = 1'b1;
    intr_n = intr_q;
    if (int_wr)      intr_n = intr_n & ~reg_wdata[1:0];
    if (ev_done_irq) intr_n[0] = 1'b1;
    if (ev_err)      intr_n[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_src <= '0; cfg_dst <= '0; cfg_len <= '0;
      cfg_cmd <= '0; cfg_fill <= '0;
      stat_q <= '0; intr_q <= '0;
      esrc_q <= '0; edst_q <= '0; elen_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          OFF_SRC:  cfg_src  <= reg_wdata[ADDR_W-1:0];
          OFF_DST:  cfg_dst  <= reg_wdata[ADDR_W-1:0];
          OFF_LEN:  cfg_len  <= reg_wdata[LEN_W-1:0];
          OFF_CMD:  cfg_cmd  <= reg_wdata;
          OFF_FILL: cfg_fill <= reg_wdata;
          default:  ;
        endcase
      end
      stat_q <= stat_n;
      intr_q <= intr_n;
      if (ev_err) begin
        esrc_q <= cap_src; edst_q <= cap_dst; elen_q <= cap_len;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_SRC:  reg_rdata = REG_W'(cfg_src);
      OFF_DST:  reg_rdata = REG_W'(cfg_dst);
      OFF_LEN:  reg_rdata = REG_W'(cfg_len);
      OFF_CMD:  reg_rdata = cfg_cmd;
      OFF_STAT: reg_rdata = stat_q | REG_W'(busy);
      OFF_INT:  reg_rdata = REG_W'(intr_q);
      OFF_FILL: reg_rdata = cfg_fill;
      OFF_ESRC: reg_rdata = REG_W'(esrc_q);
      OFF_EDST: reg_rdata = REG_W'(edst_q);
      OFF_ELEN: reg_rdata = REG_W'(elen_q);
      default:  reg_rdata = '0;
    endcase
  end

  // R8
  err_sets_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_q[1]) |-> stat_q[ST_ABORT_B]);

  // R10
  cancel_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cancel |=> stat_q[ST_ABORT_B]);

  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr && reg_wdata[0] && !ev_done_irq) |=> !intr_q[0]);
endmodule

// File: rtl/dmx_channel.sv
module dmx_channel
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              irq
);
  logic [ADDR_W-1:0] cfg_src, cfg_dst, cap_src, cap_dst;
  logic [LEN_W-1:0]  cfg_len, cap_len;
  logic [REG_W-1:0]  cfg_cmd, cfg_fill;
  logic              start, cancel, busy, ev_done_irq, ev_err, ev_cancel;
  err_cause_t        ev_cause;

  dmx_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
    .cfg_cmd(cfg_cmd), .cfg_fill(cfg_fill), .start(start), .cancel(cancel),
    .busy(busy), .ev_done_irq(ev_done_irq), .ev_err(ev_err),
    .ev_cause(ev_cause), .ev_cancel(ev_cancel),
    .cap_src(cap_src), .cap_dst(cap_dst), .cap_len(cap_len), .irq(irq)
  );

  dmx_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
    .cfg_cmd(cfg_cmd), .cfg_fill(cfg_fill),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .ev_done_irq(ev_done_irq),
    .ev_err(ev_err), .ev_cause(ev_cause), .ev_cancel(ev_cancel),
    .cap_src(cap_src), .cap_dst(cap_dst), .cap_len(cap_len)
  );

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_req && !irq));
endmodule

// File: tb/dmx_channel_bench.sv
module dmx_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] mem [0:63];
  int          n_rd = 0, n_wr = 0;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  dmx_channel u_dmx_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .irq(irq)
  );

  function automatic logic [31:0] pat(input int i);
    return 32'h5A00_0000 + (i << 8) + i;
  endfunction

  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_err   = mem_gnt && err_en && (mem_addr == err_addr);

  always @(posedge clk) begin
    mem_gnt <= rst_n && mem_req && !mem_gnt;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= pat(i);
    end else if (mem_req && mem_gnt) begin
      if (mem_we) begin
        n_wr <= n_wr + 1;
        if (!mem_err) mem[mem_addr[7:2]] <= mem_wdata;
      end else begin
        n_rd <= n_rd + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [6:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == e, tag, v, e);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(7'h24, v);
      if (!v[0]) break;
    end
  endtask

  task automatic launch(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                        input logic [31:0] c, input logic [31:0] f);
    wr(7'h00, s); wr(7'h04, d); wr(7'h08, l); wr(7'h0C, c); wr(7'h34, f);
    wr(7'h1C, 32'h1);
  endtask

  task automatic t_reset();
    expect_reg(7'h24, 32'h0, "R1 status");
    expect_reg(7'h28, 32'h0, "R1 intr");
    expect_reg(7'h40, 32'h0, "R1 err src");
    expect_reg(7'h00, 32'h0, "R1 src");
    chk(!irq && !mem_req, "R1 irq/req", {30'b0, irq, mem_req}, 32'h0);
  endtask

  task automatic t_copy_irq();
    int r0, w0, bad;
    r0 = n_rd; w0 = n_wr; bad = 0;
    launch(32'h00, 32'h80, 32'd16, 32'h0000_1000, 32'h0);
    expect_reg(7'h24, 32'h1, "R4 busy after start");
    wait_idle();
    for (int k = 0; k < 4; k++) if (mem[32 + k] != pat(k)) bad++;
    chk(bad == 0, "R2 copy data", bad, 0);
    chk(mem[36] == pat(36), "R2 copy bound", mem[36], pat(36));
    chk((n_rd - r0) == 4 && (n_wr - w0) == 4, "R2 access count", n_rd - r0, 4);
    expect_reg(7'h24, 32'h0, "R4 idle status");
    expect_reg(7'h28, 32'h1, "R5 done intr");
    chk(irq, "R11 irq high", irq, 1);
    wr(7'h28, 32'h1);
    expect_reg(7'h28, 32'h0, "R11 w1c");
    chk(!irq, "R11 irq low", irq, 0);
  endtask

  task automatic t_copy_quiet();
    launch(32'h20, 32'h60, 32'd8, 32'h0, 32'h0);
    wait_idle();
    chk(mem[24] == pat(8) && mem[25] == pat(9), "R2 quiet copy data", mem[25], pat(9));
    expect_reg(7'h28, 32'h0, "R5 no done intr");
  endtask

  task automatic t_fill();
    int r0;
    r0 = n_rd;
    launch(32'h00, 32'hC0, 32'd12, 32'h0000_100C, 32'hA5A5_3C3C);
    wait_idle();
    chk(mem[48] == 32'hA5A5_3C3C && mem[50] == 32'hA5A5_3C3C, "R3 fill data", mem[50], 32'hA5A5_3C3C);
    chk(mem[51] == pat(51), "R3 fill bound", mem[51], pat(51));
    chk(n_rd == r0, "R3 no reads", n_rd - r0, 0);
    wr(7'h28, 32'h3);
  endtask

  task automatic t_zero();
    int a0;
    a0 = n_rd + n_wr;
    launch(32'h10, 32'h20, 32'd0, 32'h0, 32'h0);
    repeat (4) @(negedge clk);
    chk((n_rd + n_wr) == a0, "R6 no access", n_rd + n_wr - a0, 0);
    expect_reg(7'h24, 32'h0010_0002, "R6 status");
    expect_reg(7'h28, 32'h2, "R6 intr");
    expect_reg(7'h40, 32'h10, "R9 err src zero");
    expect_reg(7'h44, 32'h20, "R9 err dst zero");
    expect_reg(7'h48, 32'h0, "R9 err len zero");
    wr(7'h28, 32'h2);
  endtask

  task automatic t_illegal();
    int a0;
    a0 = n_rd + n_wr;
    launch(32'h10, 32'h20, 32'd8, 32'h0000_0004, 32'h0);
    repeat (4) @(negedge clk);
    expect_reg(7'h24, 32'h0004_0002, "R7 bad op status");
    launch(32'h14, 32'h24, 32'd6, 32'h0, 32'h0);
    repeat (4) @(negedge clk);
    expect_reg(7'h24, 32'h0004_0002, "R7 unaligned status");
    expect_reg(7'h48, 32'h6, "R9 err len unaligned");
    chk((n_rd + n_wr) == a0, "R7 no access", n_rd + n_wr - a0, 0);
    expect_reg(7'h28, 32'h2, "R7 intr");
    wr(7'h28, 32'h2);
  endtask

  task automatic t_rd_err();
    int w0;
    w0 = n_wr;
    err_en = 1'b1; err_addr = 32'h08;
    launch(32'h00, 32'h80, 32'd16, 32'h0, 32'h0);
    wait_idle();
    err_en = 1'b0;
    chk((n_wr - w0) == 2, "R8 writes before read error", n_wr - w0, 2);
    expect_reg(7'h24, 32'h0001_0002, "R8 read error status");
    expect_reg(7'h28, 32'h2, "R8 error intr");
    expect_reg(7'h40, 32'h00, "R9 err src");
    expect_reg(7'h44, 32'h80, "R9 err dst");
    expect_reg(7'h48, 32'd16, "R9 err len");
    wr(7'h28, 32'h2);
  endtask

  task automatic t_wr_err();
    err_en = 1'b1; err_addr = 32'hC4;
    launch(32'h00, 32'hC0, 32'd12, 32'h0000_000C, 32'h1234_5678);
    wait_idle();
    err_en = 1'b0;
    expect_reg(7'h24, 32'h0002_0002, "R8 write error status");
    chk(mem[50] == 32'hA5A5_3C3C, "R8 stop after write error", mem[50], 32'hA5A5_3C3C);
    wr(7'h28, 32'h2);
  endtask

  task automatic t_restart();
    launch(32'h00, 32'hF0, 32'd4, 32'h0000_000C, 32'h0BAD_F00D);
    wait_idle();
    expect_reg(7'h24, 32'h0, "R12 stale bits cleared");
    chk(mem[60] == 32'h0BAD_F00D, "R12 restart data", mem[60], 32'h0BAD_F00D);
  endtask

  task automatic t_cancel();
    int a0;
    launch(32'h00, 32'h80, 32'd64, 32'h0000_1000, 32'h0);
    repeat (6) @(negedge clk);
    wr(7'h1C, 32'h0);
    a0 = n_rd + n_wr;
    repeat (10) @(negedge clk);
    chk((n_rd + n_wr) == a0, "R10 no access after cancel", n_rd + n_wr - a0, 0);
    chk(!mem_req, "R10 req low", mem_req, 0);
    expect_reg(7'h24, 32'h2, "R10 aborted status");
    expect_reg(7'h28, 32'h0, "R10 no intr");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_irq();
    t_copy_quiet();
    t_fill();
    t_zero();
    t_illegal();
    t_rd_err();
    t_wr_err();
    t_restart();
    t_cancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule